// File: doc/BRIEF.md
# Packed Lane Saturating ALU

This block is a 64-bit integer datapath that splits each operand into independent lanes of 8, 16 or 32 bits, chosen per operation. It adds and subtracts lane by lane with plain wrap-around, signed clamping or unsigned clamping. It compares lanes for equality or signed greater-than and writes a full-lane mask. It shifts each lane left or right, logically or arithmetically, by a common amount. It applies bitwise logic to the whole word. It also narrows signed elements to half their width with clamping, packing two operands into one word.

Operands, opcode, lane size and shift amount are sampled on a rising clock edge. The result appears on `result` from that edge on, so it is readable one clock after the inputs were set up. Carries, borrows and shifted-out bits never move from one lane into its neighbour.

Top module: `simd_sat_alu`

## Requirements
- R1: While `rst_n` is low, `result` is zero. Otherwise `result` takes the outcome of the inputs present at each rising clock edge and holds it until the next edge.
- R2: `lane_sz` selects the lane width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Opcode 0 (add) and opcode 3 (subtract) wrap modulo the lane width, and no carry or borrow crosses a lane boundary.
- R3: Opcode 1 (add) and opcode 4 (subtract) treat lanes as two's-complement. A lane that overflows is clamped to the lane's most negative or most positive value.
- R4: Opcode 2 (add) and opcode 5 (subtract) treat lanes as unsigned. An add that overflows gives all ones in that lane, and a subtract that underflows gives zero.
- R5: Opcode 6 sets a lane to all ones when the operand lanes are equal. Opcode 7 sets a lane to all ones when the `op_a` lane is greater than the `op_b` lane as a signed value. Every other lane is zero.
- R6: Opcode 8 shifts each `op_a` lane left, opcode 9 shifts it right filling with zeros, and opcode 10 shifts it right filling with the lane's sign bit. The shift distance is `shamt`, for distances below the lane width.
- R7: When `shamt` is at or above the lane width, opcodes 8 and 9 give zero lanes and opcode 10 gives each lane filled with its sign bit.
- R8: Opcode 11 gives a AND b, opcode 12 gives (NOT a) AND b, opcode 13 gives a OR b and opcode 14 gives a XOR b. All four act on the whole word, whatever `lane_sz` is.
- R9: Opcode 15 narrows each signed lane to half its width with signed clamping. With `lane_sz` 1, 16-bit lanes become bytes. With `lane_sz` 2 or 3, 32-bit lanes become 16-bit values. The narrowed lanes of `op_a` fill the low half in lane order, and those of `op_b` fill the high half. With `lane_sz` 0 the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| opcode | input | 4 | Operation code (see R2 to R9) |
| lane_sz | input | 2 | Lane width select |
| shamt | input | 6 | Shift distance for opcodes 8 to 10 |
| result | output | 64 | Registered packed result |

## Verification
The bench builds the block with its default 64-bit word. That gives eight, four or two lanes, so every lane width has a lowest lane, a highest lane and at least one inner boundary where a leaked carry, borrow or shifted bit would show. Shift distances just below, at and above each lane width are reachable with the 6-bit `shamt`. The pack vectors put out-of-range values in both the `op_a` and `op_b` halves, so the clamping and the ordering of the two halves are seen together.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDS  = 4'd1,
        OP_ADDUS = 4'd2,
        OP_SUB   = 4'd3,
        OP_SUBS  = 4'd4,
        OP_SUBUS = 4'd5,
        OP_CMPEQ = 4'd6,
        OP_CMPGT = 4'd7,
        OP_SLL   = 4'd8,
        OP_SRL   = 4'd9,
        OP_SRA   = 4'd10,
        OP_AND   = 4'd11,
        OP_ANDN  = 4'd12,
        OP_OR    = 4'd13,
        OP_XOR   = 4'd14,
        OP_PACK  = 4'd15
    } simd_op_e;

    typedef enum logic [1:0] {
        LS_8  = 2'd0,
        LS_16 = 2'd1,
        LS_32 = 2'd2,
        LS_32B = 2'd3
    } lane_sz_e;

    localparam int NUM_SIZES = 3;

endpackage

// File: rtl/simd_lane.sv
`timescale 1ns/1ps
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8,
    parameter int SH_W = 6
) (
    input  simd_op_e        op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [SH_W-1:0] shamt,
    output logic [W-1:0]    y
);
    localparam logic [SH_W:0] WLIM = (SH_W+1)'(W);
    localparam logic [W-1:0]  SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]  SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum_x;
    logic [W:0] dif_x;
    logic       s_ovf_add;
    logic       s_ovf_sub;
    logic       wide_sh;

    always_comb begin
        sum_x     = {1'b0, a} + {1'b0, b};
        dif_x     = {1'b0, a} - {1'b0, b};
        s_ovf_add = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
        s_ovf_sub = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
        wide_sh   = {1'b0, shamt} >= WLIM;
    end

    always_comb begin
        y = '0;
        unique case (op)
            OP_ADD:   y = sum_x[W-1:0];
            OP_SUB:   y = dif_x[W-1:0];
            OP_ADDS:  y = s_ovf_add ? (a[W-1] ? SMIN : SMAX) : sum_x[W-1:0];
            OP_SUBS:  y = s_ovf_sub ? (a[W-1] ? SMIN : SMAX) : dif_x[W-1:0];
            OP_ADDUS: y = sum_x[W] ? {W{1'b1}} : sum_x[W-1:0];
            OP_SUBUS: y = dif_x[W] ? '0 : dif_x[W-1:0];
            OP_CMPEQ: y = (a == b) ? {W{1'b1}} : '0;
            OP_CMPGT: y = ($signed(a) > $signed(b)) ? {W{1'b1}} : '0;
            OP_SLL:   y = wide_sh ? '0 : (a << shamt);
            OP_SRL:   y = wide_sh ? '0 : (a >> shamt);
            OP_SRA:   y = wide_sh ? {W{a[W-1]}} : W'($signed(a) >>> shamt);
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/simd_pack.sv
`timescale 1ns/1ps
module simd_pack
    import simd_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  lane_sz_e      lsz,
    output logic [DW-1:0] y
);
    localparam int HALF = DW / 2;
    localparam int N16  = DW / 16;
    localparam int N32  = DW / 32;

    function automatic logic [7:0] clamp8(input logic [15:0] x);
        if (x[15] && !(&x[14:7]))      return 8'h80;
        else if (!x[15] && (|x[14:7])) return 8'h7F;
        else                           return x[7:0];
    endfunction

    function automatic logic [15:0] clamp16(input logic [31:0] x);
        if (x[31] && !(&x[30:15]))      return 16'h8000;
        else if (!x[31] && (|x[30:15])) return 16'h7FFF;
        else                            return x[15:0];
    endfunction

    logic [DW-1:0] from16;
    logic [DW-1:0] from32;

    for (genvar i = 0; i < N16; i++) begin : g_n16
        assign from16[8*i +: 8]        = clamp8(a[16*i +: 16]);
        assign from16[HALF + 8*i +: 8] = clamp8(b[16*i +: 16]);
    end

    for (genvar i = 0; i < N32; i++) begin : g_n32
        assign from32[16*i +: 16]        = clamp16(a[32*i +: 32]);
        assign from32[HALF + 16*i +: 16] = clamp16(b[32*i +: 32]);
    end

    always_comb begin
        unique case (lsz)
            LS_8:    y = '0;
            LS_16:   y = from16;
            default: y = from32;
        endcase
    end
endmodule

// File: rtl/simd_sat_alu.sv
`timescale 1ns/1ps
module simd_sat_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SH_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        opcode,
    input  logic [1:0]        lane_sz,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] result
);
    simd_op_e      op_e;
    lane_sz_e      lsz_e;
    logic [DATA_W-1:0] lane_res [NUM_SIZES];
    logic [DATA_W-1:0] pack_res;
    logic [DATA_W-1:0] next_res;

    assign op_e  = simd_op_e'(opcode);
    assign lsz_e = lane_sz_e'(lane_sz);

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int LW = 8 << s;
        localparam int NL = DATA_W / LW;
        for (genvar j = 0; j < NL; j++) begin : g_lane
            simd_lane #(.W(LW), .SH_W(SH_W)) u_lane (
                .op    (op_e),
                .a     (op_a[LW*j +: LW]),
                .b     (op_b[LW*j +: LW]),
                .shamt (shamt),
                .y     (lane_res[s][LW*j +: LW])
            );
        end
    end

    simd_pack #(.DW(DATA_W)) u_pack (
        .a   (op_a),
        .b   (op_b),
        .lsz (lsz_e),
        .y   (pack_res)
    );

    always_comb begin
        unique case (op_e)
            OP_AND:  next_res = op_a & op_b;
            OP_ANDN: next_res = ~op_a & op_b;
            OP_OR:   next_res = op_a | op_b;
            OP_XOR:  next_res = op_a ^ op_b;
            OP_PACK: next_res = pack_res;
            default: begin
                unique case (lsz_e)
                    LS_8:    next_res = lane_res[0];
                    LS_16:   next_res = lane_res[1];
                    default: next_res = lane_res[2];
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result <= '0;
        else        result <= next_res;
    end
endmodule

// File: rtl/simd_sat_alu_chk.sv
`timescale 1ns/1ps
module simd_sat_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic [3:0]  opcode,
    input logic [1:0]  lane_sz,
    input logic [5:0]  shamt,
    input logic [63:0] result
);
    function automatic logic bytes_are_masks(input logic [63:0] v);
        logic ok = 1'b1;
        for (int i = 0; i < 8; i++)
            ok &= (v[8*i +: 8] == 8'h00) || (v[8*i +: 8] == 8'hFF);
        return ok;
    endfunction

    function automatic logic bytes_ge(input logic [63:0] v, input logic [63:0] r);
        logic ok = 1'b1;
        for (int i = 0; i < 8; i++) ok &= (v[8*i +: 8] >= r[8*i +: 8]);
        return ok;
    endfunction

    function automatic logic bytes_le(input logic [63:0] v, input logic [63:0] r);
        logic ok = 1'b1;
        for (int i = 0; i < 8; i++) ok &= (v[8*i +: 8] <= r[8*i +: 8]);
        return ok;
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> result == 64'd0); // R1

    AST_CMP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == 4'd6 || opcode == 4'd7) && lane_sz == 2'd0) |=> bytes_are_masks(result)); // R5

    AST_ADDUS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd2 && lane_sz == 2'd0) |=> bytes_ge(result, $past(op_a))); // R4

    AST_SUBUS_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd5 && lane_sz == 2'd0) |=> bytes_le(result, $past(op_a))); // R4

    AST_XOR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd14) |=> result == ($past(op_a) ^ $past(op_b))); // R8

    AST_SRL_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd9 && shamt >= 6'd32) |=> result == 64'd0); // R7

    AST_PACK_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd15 && lane_sz == 2'd0) |=> result == 64'd0); // R9
endmodule

bind simd_sat_alu simd_sat_alu_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .opcode  (opcode),
    .lane_sz (lane_sz),
    .shamt   (shamt),
    .result  (result)
);

// File: tb/tb_simd_sat_alu.sv
`timescale 1ns/1ps
module tb_simd_sat_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  opcode = '0;
    logic [1:0]  lane_sz = '0;
    logic [5:0]  shamt = '0;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    simd_sat_alu dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .opcode(opcode), .lane_sz(lane_sz), .shamt(shamt), .result(result)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  lsz;
        logic [5:0]  sh;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        // R2 wrap add/sub, lanes isolated
        '{4'd0, 2'd0, 6'd0, 64'hFF01_0203_0405_0607, 64'h0101_0101_0101_0101, 64'h0002_0304_0506_0708, 8'd2},
        '{4'd0, 2'd1, 6'd0, 64'h00FF_00FF_FFFF_0001, 64'h0001_0001_0001_0001, 64'h0100_0100_0000_0002, 8'd2},
        '{4'd3, 2'd2, 6'd0, 64'h0000_0002_0000_0000, 64'h0000_0001_0000_0001, 64'h0000_0001_FFFF_FFFF, 8'd2},
        '{4'd0, 2'd3, 6'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 8'd2},
        // R3 signed clamping
        '{4'd1, 2'd0, 6'd0, 64'h7F80_10F0_7F80_01FF, 64'h01FF_20F0_7F80_FF01, 64'h7F80_30E0_7F80_0000, 8'd3},
        '{4'd4, 2'd1, 6'd0, 64'h8000_7FFF_0005_FFFF, 64'h0001_FFFF_0007_7FFF, 64'h8000_7FFF_FFFE_8000, 8'd3},
        // R4 unsigned clamping
        '{4'd2, 2'd0, 6'd0, 64'hFF80_0102_F0F0_0000, 64'h0180_FE02_0F10_0000, 64'hFFFF_FF04_FFFF_0000, 8'd4},
        '{4'd5, 2'd2, 6'd0, 64'h0000_0005_8000_0000, 64'h0000_0006_7FFF_FFFF, 64'h0000_0000_0000_0001, 8'd4},
        // R5 compare masks
        '{4'd6, 2'd1, 6'd0, 64'h1234_5678_0000_FFFF, 64'h1234_5679_0000_FFFE, 64'hFFFF_0000_FFFF_0000, 8'd5},
        '{4'd7, 2'd0, 6'd0, 64'h01FF_807F_0505_00FE, 64'h0001_7F80_0504_FFFF, 64'hFF00_00FF_00FF_FF00, 8'd5},
        // R6 shifts below lane width
        '{4'd8, 2'd1, 6'd4, 64'h1234_8001_F00F_0001, 64'h0, 64'h2340_0010_00F0_0010, 8'd6},
        '{4'd9, 2'd0, 6'd1, 64'h80FF_0102_0304_7F01, 64'h0, 64'h407F_0001_0102_3F00, 8'd6},
        '{4'd10, 2'd2, 6'd4, 64'h8000_0010_7FFF_FFF0, 64'h0, 64'hF800_0001_07FF_FFFF, 8'd6},
        '{4'd10, 2'd2, 6'd31, 64'h8000_0000_7FFF_FFFF, 64'h0, 64'hFFFF_FFFF_0000_0000, 8'd6},
        // R7 shifts at or above lane width
        '{4'd9, 2'd0, 6'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 8'd7},
        '{4'd10, 2'd1, 6'd20, 64'h8000_7FFF_FFFF_0001, 64'h0, 64'hFFFF_0000_FFFF_0000, 8'd7},
        '{4'd8, 2'd2, 6'd32, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 8'd7},
        // R8 word logic
        '{4'd11, 2'd0, 6'd0, 64'hF0F0_F0F0_FF00_FF00, 64'hFFFF_0000_0F0F_0F0F, 64'hF0F0_0000_0F00_0F00, 8'd8},
        '{4'd12, 2'd0, 6'd0, 64'hF0F0_F0F0_FF00_FF00, 64'hFFFF_0000_0F0F_0F0F, 64'h0F0F_0000_000F_000F, 8'd8},
        '{4'd13, 2'd2, 6'd0, 64'hF0F0_F0F0_FF00_FF00, 64'hFFFF_0000_0F0F_0F0F, 64'hFFFF_F0F0_FF0F_FF0F, 8'd8},
        '{4'd14, 2'd1, 6'd0, 64'hF0F0_F0F0_FF00_FF00, 64'hFFFF_0000_0F0F_0F0F, 64'h0F0F_F0F0_F00F_F00F, 8'd8},
        // R9 narrowing pack
        '{4'd15, 2'd1, 6'd0, 64'h0080_FF7F_007F_FFFF, 64'h0001_FF80_1234_8000, 64'h0180_7F80_7F80_7FFF, 8'd9},
        '{4'd15, 2'd2, 6'd0, 64'h0000_8000_FFFF_7FFF, 64'h0000_1234_FFFF_FFFE, 64'h1234_FFFE_7FFF_8000, 8'd9},
        '{4'd15, 2'd0, 6'd0, 64'h7FFF_8000_1234_0001, 64'h0001_0002_0003_0004, 64'h0, 8'd9}
    };

    task automatic check(input logic [63:0] exp, input int req, input string what);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, result, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        opcode = v.op; lane_sz = v.lsz; shamt = v.sh; op_a = v.a; op_b = v.b;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(64'h0, 1, "reset value");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            check(TBL[i].e, int'(TBL[i].req), $sformatf("vector %0d", i));
        end

        // R1: result holds until the next edge, then follows new inputs
        drive(TBL[0]);
        @(negedge clk);
        opcode = 4'd14; op_a = 64'hAAAA_AAAA_AAAA_AAAA; op_b = 64'h5555_5555_5555_5555;
        #1;
        check(TBL[0].e, 1, "held before edge");
        @(negedge clk);
        check(64'hFFFF_FFFF_FFFF_FFFF, 1, "updated after edge");

        // R1: reset mid-run clears the result
        rst_n = 1'b0;
        #1;
        check(64'h0, 1, "async reset clear");
        @(negedge clk);
        check(64'h0, 1, "held in reset");
        rst_n = 1'b1;

        // R2: borrow stays inside an 8-bit lane at the top boundary
        drive('{4'd3, 2'd0, 6'd0, 64'h0100_0000_0000_0000, 64'h0001_0000_0000_0001, 64'h0, 8'd2});
        @(negedge clk);
        check(64'h01FF_0000_0000_00FF, 2, "byte borrow isolation");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule